// File: doc/BRIEF.md
# Ones' Complement Adder/Subtractor

This block adds or subtracts two signed words held in ones' complement form and returns the answer one clock later from registered outputs. Each word is either positive, with the magnitude held directly, or negative, with the magnitude held as the bitwise inverse. So zero has two spellings: all zeros (positive zero) and all ones (negative zero). Subtraction is addition of the inverted second operand. The carry or borrow leaving the top bit is folded back into the bottom bit, which gives arithmetic modulo 2^W - 1.

An elaboration parameter selects the arithmetic core. The adding core sums the first operand and the effective addend, with end-around carry. The subtracting core takes the first operand minus the inverse of the effective addend, with end-around borrow. The two cores give the same nonzero results. They differ only in which zero spelling a zero result takes: the subtracting core almost never gives negative zero. A second parameter can fold every negative-zero result into positive zero. Flags report any zero, negative zero specifically, and signed overflow.

Top module: `oc_addsub`

## Requirements
- R1: Words are W bits (default 16). Bit W-1 is the sign. A word with bit W-1 clear has the value of its bits. A word with bit W-1 set has the negated value of its bitwise inverse. All zeros is +0 and all ones is -0.
- R2: With `op_sub`=0, the registered result one cycle later is the encoding of a+b. When the sum is nonzero and in range, its encoding is unique.
- R3: With `op_sub`=1, the registered result one cycle later is the encoding of a-b. The effective addend is then the bitwise inverse of b; otherwise it is b.
- R4: With `CORE`=CORE_ADD, a result whose value is zero comes out as all zeros only when the first operand and the effective addend are both all zeros. Every other zero result comes out as all ones.
- R5: With `CORE`=CORE_SUB, a result whose value is zero comes out as all ones only when the first operand and the effective addend are both all ones. Every other zero result comes out as all zeros.
- R6: `zero_q` is 1 exactly when the result is all zeros or all ones. `negzero_q` is 1 exactly when the result is all ones.
- R7: With `NORM_ZERO`=1, an all-ones result is replaced by all zeros, and `negzero_q` stays 0.
- R8: `ovf_q` is 1 when the first operand and the effective addend have the same sign and the unnormalised result has the other sign. In that case the result encodes the true value minus (2^W-1) for a positive true value, or plus (2^W-1) for a negative one.
- R9: While `rst` is high at a clock edge, the result and all flags are cleared to 0 at that edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | W | First operand, ones' complement |
| opnd_b | input | W | Second operand, ones' complement |
| op_sub | input | 1 | 0 adds, 1 subtracts the second operand |
| sum_q | output | W | Registered result |
| zero_q | output | 1 | Result is either zero spelling |
| negzero_q | output | 1 | Result is all ones |
| ovf_q | output | 1 | Signed overflow of the operation |

## Verification
Every stage of the block sits between the operand ports and one register, so any fault shows at the ports on the very next clock.

A missing end-around carry or borrow gives results that are off by one on mixed-sign operands. A swapped core or a wrong normalisation choice changes only the zero spelling, so the bench aims several patterns at each zero-producing combination on three configurations. A faulty sign comparison shows up as a wrong `ovf_q` on the range edges, such as the largest positive value plus one or two large negative values added together.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    CORE_ADD = 1'b0,
    CORE_SUB = 1'b1
  } core_kind_e;
endpackage

// File: rtl/oc_eac_adder.sv
// Sum of two words with the carry out of the top bit added back in at bit 0.
module oc_eac_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  logic [W:0] first;

  always_comb begin
    first = {1'b0, x} + {1'b0, y};
    // The low part is at most 2^W-2 when a carry exists, so this never carries again.
    sum = first[W-1:0] + {{(W-1){1'b0}}, first[W]};
  end
endmodule

// File: rtl/oc_eab_subtractor.sv
// Difference of two words with the borrow out of the top bit taken off at bit 0.
module oc_eab_subtractor #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] diff
);
  logic [W:0] first;

  always_comb begin
    first = {1'b0, x} - {1'b0, y};
    // The low part is at least 1 when a borrow exists, so this never borrows again.
    diff = first[W-1:0] - {{(W-1){1'b0}}, first[W]};
  end
endmodule

// File: rtl/oc_zero_fold.sv
// Zero detection and optional folding of negative zero into positive zero.
module oc_zero_fold #(
  parameter int W         = 16,
  parameter bit NORM_ZERO = 1'b0
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] word,
  output logic         is_zero,
  output logic         is_negzero
);
  logic raw_all_ones;
  logic raw_all_zero;

  assign raw_all_ones = &raw;
  assign raw_all_zero = ~|raw;

  generate
    if (NORM_ZERO) begin : g_fold
      assign word       = raw_all_ones ? '0 : raw;
      assign is_negzero = 1'b0;
    end else begin : g_keep
      assign word       = raw;
      assign is_negzero = raw_all_ones;
    end
  endgenerate

  assign is_zero = raw_all_ones | raw_all_zero;
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub #(
  parameter int                 W         = 16,
  parameter oc_pkg::core_kind_e CORE      = oc_pkg::CORE_ADD,
  parameter bit                 NORM_ZERO = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         op_sub,
  output logic [W-1:0] sum_q,
  output logic         zero_q,
  output logic         negzero_q,
  output logic         ovf_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam int           SB       = W - 1;

  logic [W-1:0] b_eff;
  logic [W-1:0] raw;
  logic [W-1:0] word;
  logic         is_zero;
  logic         is_negzero;
  logic         ovf_c;
  logic         primed_q;

  // Subtraction adds the inverted second operand.
  assign b_eff = op_sub ? ~opnd_b : opnd_b;

  generate
    if (CORE == oc_pkg::CORE_ADD) begin : g_add_core
      oc_eac_adder #(.W(W)) u_core (
        .x  (opnd_a),
        .y  (b_eff),
        .sum(raw)
      );
    end else begin : g_sub_core
      logic [W-1:0] b_neg;
      assign b_neg = ~b_eff;
      oc_eab_subtractor #(.W(W)) u_core (
        .x   (opnd_a),
        .y   (b_neg),
        .diff(raw)
      );
    end
  endgenerate

  assign ovf_c = (opnd_a[SB] == b_eff[SB]) && (raw[SB] != opnd_a[SB]);

  oc_zero_fold #(.W(W), .NORM_ZERO(NORM_ZERO)) u_fold (
    .raw       (raw),
    .word      (word),
    .is_zero   (is_zero),
    .is_negzero(is_negzero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      zero_q    <= 1'b0;
      negzero_q <= 1'b0;
      ovf_q     <= 1'b0;
      primed_q  <= 1'b0;
    end else begin
      sum_q     <= word;
      zero_q    <= is_zero;
      negzero_q <= is_negzero;
      ovf_q     <= ovf_c;
      primed_q  <= 1'b1;
    end
  end

  assert_negzero_in_zero_R6: assert property (@(posedge clk) disable iff (rst)
    negzero_q |-> zero_q)
    else $error("negative-zero flag without zero flag");

  assert_ovf_sign_R8: assert property (@(posedge clk) disable iff (rst)
    (primed_q && ovf_q) |->
      (($past(opnd_a[SB]) == $past(b_eff[SB])) && (sum_q[SB] != $past(opnd_a[SB]))))
    else $error("overflow flag without sign mismatch");

  generate
    if (NORM_ZERO) begin : g_chk_norm
      assert_no_negzero_R7: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> (!negzero_q && (sum_q != ALL_ONES)))
        else $error("negative zero escaped normalisation");
    end else if (CORE == oc_pkg::CORE_ADD) begin : g_chk_add
      assert_add_poszero_R4: assert property (@(posedge clk) disable iff (rst)
        (primed_q && (sum_q == '0)) |-> (($past(opnd_a) == '0) && ($past(b_eff) == '0)))
        else $error("adding core gave +0 from non-zero addends");
    end else begin : g_chk_sub
      assert_sub_negzero_R5: assert property (@(posedge clk) disable iff (rst)
        (primed_q && (sum_q == ALL_ONES)) |->
          (($past(opnd_a) == ALL_ONES) && ($past(b_eff) == ALL_ONES)))
        else $error("subtracting core gave -0 from other operands");
    end
  endgenerate
endmodule

// File: tb/test_oc_addsub.sv
module test_oc_addsub;
  localparam int W = 8;
  localparam int M = (1 << (W - 1)) - 1;
  localparam int MOD = (1 << W) - 1;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic op = 1'b0;

  logic [W-1:0] s0, s1, s2;
  logic z0, z1, z2, n0, n1, n2, v0, v1, v2;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  oc_addsub #(.W(W), .CORE(oc_pkg::CORE_ADD), .NORM_ZERO(1'b0)) i_oc_addsub (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .op_sub(op),
    .sum_q(s0), .zero_q(z0), .negzero_q(n0), .ovf_q(v0));

  oc_addsub #(.W(W), .CORE(oc_pkg::CORE_SUB), .NORM_ZERO(1'b0)) i_oc_addsub_sub (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .op_sub(op),
    .sum_q(s1), .zero_q(z1), .negzero_q(n1), .ovf_q(v1));

  oc_addsub #(.W(W), .CORE(oc_pkg::CORE_ADD), .NORM_ZERO(1'b1)) i_oc_addsub_norm (
    .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .op_sub(op),
    .sum_q(s2), .zero_q(z2), .negzero_q(n2), .ovf_q(v2));

  // R1: value of a ones' complement word
  function automatic int val(logic [W-1:0] x);
    logic [W-1:0] inv;
    inv = ~x;
    return x[W-1] ? -int'(inv) : int'(x);
  endfunction

  function automatic logic [W-1:0] enc(int v);
    logic [W-1:0] mag;
    mag = W'(v < 0 ? -v : v);
    return (v < 0) ? ~mag : mag;
  endfunction

  task automatic chk(string what, string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // kind 0: adding core, 1: subtracting core; norm folds -0
  task automatic check_cfg(string name, int kind, bit norm, string rtag,
                           logic [W-1:0] ta, logic [W-1:0] tb, logic top,
                           logic [W-1:0] gs, logic gz, logic gn, logic gv);
    int sv;
    bit ovf;
    logic [W-1:0] beff, res;
    string ztag;
    beff = top ? ~tb : tb;
    sv = val(ta) + (top ? -val(tb) : val(tb));
    ovf = (sv > M) || (sv < -M);
    ztag = rtag;
    if (ovf) begin
      res = enc(sv > 0 ? sv - MOD : sv + MOD);
      ztag = "R8";
    end else if (sv == 0) begin
      if (kind == 0) begin
        res = (ta == '0 && beff == '0) ? '0 : ONES;
        ztag = "R4";
      end else begin
        res = (ta == ONES && beff == ONES) ? ONES : '0;
        ztag = "R5";
      end
    end else begin
      res = enc(sv);
    end
    if (norm && res == ONES) begin
      res = '0;
      ztag = "R7";
    end
    chk({name, " result"}, ztag, int'(gs), int'(res));
    chk({name, " zero flag"}, "R6", int'(gz), int'(res == '0 || res == ONES));
    chk({name, " negzero flag"}, norm ? "R7" : "R6", int'(gn), int'(res == ONES));
    chk({name, " overflow"}, "R8", int'(gv), int'(ovf));
  endtask

  task automatic step(logic [W-1:0] ta, logic [W-1:0] tb, logic top, string rtag);
    a = ta;
    b = tb;
    op = top;
    @(negedge clk);
    check_cfg("add-core", 0, 1'b0, rtag, ta, tb, top, s0, z0, n0, v0);
    check_cfg("sub-core", 1, 1'b0, rtag, ta, tb, top, s1, z1, n1, v1);
    check_cfg("norm", 0, 1'b1, rtag, ta, tb, top, s2, z2, n2, v2);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    a = 8'h5A;
    b = 8'h33;
    op = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset clears everything even with live inputs
    chk("reset result", "R9", int'({s0, s1, s2}), 0);
    chk("reset flags", "R9", int'({z0, n0, v0, z1, n1, v1, z2, n2, v2}), 0);
    rst = 1'b0;

    step(8'd5, 8'd3, 1'b0, "R2");
    step(8'hFA, 8'd9, 1'b0, "R1");       // -5 + 9 needs the end-around carry
    step(8'd9, 8'hFA, 1'b1, "R3");       // 9 - (-5) = 14
    step(8'd20, 8'd30, 1'b1, "R3");      // 20 - 30 = -10
    step(8'h00, 8'h00, 1'b0, "R4");      // +0 + +0
    step(8'd5, 8'hFA, 1'b0, "R4");       // 5 + -5
    step(8'hFF, 8'hFF, 1'b0, "R5");      // -0 + -0
    step(8'd5, 8'd5, 1'b1, "R5");        // 5 - 5
    step(8'h00, 8'h00, 1'b1, "R4");      // +0 - +0: effective addend all ones
    step(8'hFF, 8'h00, 1'b1, "R5");      // -0 - +0
    step(8'h00, 8'hFF, 1'b0, "R4");      // +0 + -0
    step(8'd127, 8'd1, 1'b0, "R8");      // largest positive plus one
    step(8'h80, 8'h80, 1'b0, "R8");      // -127 + -127
    step(8'd127, 8'h80, 1'b1, "R8");     // 127 - (-127)
    step(8'd127, 8'h80, 1'b0, "R2");     // 127 + -127 = zero

    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] ra, rb;
      logic ro;
      ra = W'($urandom);
      rb = W'($urandom);
      ro = 1'(($urandom >> 3) & 1);
      if (i % 7 == 0) rb = ro ? ra : ~ra;   // force zero-valued results
      step(ra, rb, ro, ro ? "R3" : "R2");
    end

    rst = 1'b1;
    @(negedge clk);
    chk("reset again", "R9", int'({s0, z0, n0, v0}), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule